// File: doc/BRIEF.md
# Host Bus Style Auto-Detector

This block sits on the pins of an 8-bit microcontroller bus in front of a peripheral's register file. Glue logic is not needed, because the block learns the host's bus conventions by watching the first few accesses after hardware reset. It makes two decisions. The first is whether the host drives separate active-low read and write strobes, or a direction line plus an active-low data strobe. The second is whether the low address bits arrive on the shared address/data lines, qualified by an address latch enable (multiplexed), or on dedicated address pins (non-multiplexed).

All host pins are sampled on the block clock through a parameterised number of register stages. While the block is still learning, the strobe style is set by the first write the host performs. The multiplexing choice is set by any high level seen on the lowest address pin. The first read that selects the device with chip select freezes both choices until the next reset. Throughout, the block turns host activity into single-cycle internal read, write and address-capture pulses, together with a register address and the write data. A three-bit status output shows the learned modes.

Top module: `hbus_detect`

## Requirements
- R1: After reset, `mode_status` is 3'b000. Bit 0 is 0 for separate strobes and 1 for direction plus data strobe. Bit 1 is 0 for multiplexed and 1 for non-multiplexed. Bit 2 is 1 once the modes are locked.
- R2: A low-then-high pulse on `host_wr_n` while `host_rd_n` stays high selects separate strobes. Bit 0 stays 0.
- R3: A falling edge on `host_rd_n` while `host_wr_n` has already been low for at least one sample selects direction plus data strobe, and bit 0 becomes 1. In that style `host_wr_n` is the direction line (1 means read, 0 means write) and `host_rd_n` is the active-low data strobe.
- R4: Any sampled high level on `host_addr[0]` before lock sets bit 1. It then stays set.
- R5: When `host_cs_n` is low together with an active read strobe of the current style, bit 2 becomes 1. After that, no pin activity changes bits 0 or 1 until reset.
- R6: The first strobe-style decision holds even before lock. Traffic shaped like the other style does not change bit 0.
- R7: With separate strobes and chip select low, each write gives one `reg_wr` pulse after `host_wr_n` rises, with `reg_wdata` equal to the data lines just before the rise. Each read gives one `reg_rd` pulse when `host_rd_n` falls.
- R8: With direction plus data strobe and chip select low, a data-strobe pulse with direction 0 gives one `reg_wr` pulse carrying the data lines. A data-strobe pulse with direction 1 gives one `reg_rd` pulse.
- R9: In multiplexed mode, each falling edge of `host_ale` loads `reg_addr` from the low `ADDR_W` bits of `host_ad` and pulses `addr_stb` once. The data phase leaves `reg_addr` unchanged.
- R10: In non-multiplexed mode, `reg_addr` is loaded from `host_addr` at the start of each selected access, and `addr_stb` pulses once per access.
- R11: With `host_cs_n` high, strobe activity produces no `reg_rd` or `reg_wr` pulse.
- R12: `reg_rd` and `reg_wr` are never high in the same cycle. `reg_rd` is only high while bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the host pins |
| rst_n | input | 1 | Active-low hardware reset |
| host_cs_n | input | 1 | Active-low chip select |
| host_rd_n | input | 1 | Read strobe, or data strobe in direction style |
| host_wr_n | input | 1 | Write strobe, or direction line in direction style |
| host_ale | input | 1 | Address latch enable, multiplexed mode |
| host_addr | input | ADDR_W | Dedicated address pins; bit 0 also senses multiplexing |
| host_ad | input | DATA_W | Data lines, carrying the address phase in multiplexed mode |
| reg_rd | output | 1 | One-cycle internal read pulse |
| reg_wr | output | 1 | One-cycle internal write pulse |
| reg_addr | output | ADDR_W | Register address for the current access |
| reg_wdata | output | DATA_W | Write data that goes with `reg_wr` |
| addr_stb | output | 1 | One-cycle pulse when `reg_addr` is loaded |
| mode_status | output | 3 | {locked, non-multiplexed, direction style} |

## Verification
The bench covers all four combinations of strobe style and multiplexing. In each one it sweeps every register address with arithmetic write data, so a design that picked its address from the wrong phase, or produced two strobe pulses per access, would miscompare on most addresses. The first write in direction style starts with the direction line falling. A detector that treats any write-pin edge as a separate-strobe pulse would misclassify that host. It would also emit a stray read pulse before the style settles. After classification, and again after lock, the bench drives traffic shaped like the other style and raises the lowest address pin with chip select high. A design without sticky, frozen mode bits would let its status drift there, and one without chip-select gating would emit pulses.

// File: rtl/hbus_detect_pkg.sv
package hbus_detect_pkg;

   typedef enum logic {
      STROBE_SPLIT = 1'b0,
      STROBE_DIRDS = 1'b1
   } strobe_style_e;

   typedef struct packed {
      logic cs_n;
      logic rd_n;
      logic wr_n;
      logic ale;
   } host_ctl_t;

   localparam int CTL_W      = 4;
   localparam int STAT_STYLE = 0;
   localparam int STAT_DEMUX = 1;
   localparam int STAT_LOCK  = 2;
   localparam int STAT_W     = 3;

endpackage

// File: rtl/hbd_sampler.sv
module hbd_sampler #(
   parameter int             W      = 8,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   output logic [W-1:0] now_q,
   output logic [W-1:0] prev_q
);

   localparam int DEPTH = STAGES + 1;

   generate
      if (STAGES < 1 || STAGES > 3) begin : g_bad_stages
         $error("hbd_sampler: STAGES must be 1 to 3");
      end
   endgenerate

   logic [DEPTH-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {DEPTH{RST}};
      end else begin
         chain[0] <= pins;
         for (int i = 1; i < DEPTH; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign now_q  = chain[STAGES-1];
   assign prev_q = chain[STAGES];

endmodule

// File: rtl/hbd_style.sv
module hbd_style
   import hbus_detect_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          freeze,
   input  host_ctl_t     now_c,
   input  host_ctl_t     prev_c,
   output strobe_style_e style_q,
   output logic          dirds_eff
);

   logic decided_q;
   logic pick_dirds;
   logic pick_split;

   always_comb begin
      // data strobe falls while the direction line is settled low: direction style
      pick_dirds = !decided_q && !freeze &&
                   prev_c.rd_n && !now_c.rd_n &&
                   !now_c.wr_n && !prev_c.wr_n;
      // the write pin finishes a pulse with no read-pin activity: separate strobes
      pick_split = !decided_q && !freeze &&
                   !prev_c.wr_n && now_c.wr_n;
      dirds_eff  = (style_q == STROBE_DIRDS) || pick_dirds;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         decided_q <= 1'b0;
         style_q   <= STROBE_SPLIT;
      end else if (pick_dirds) begin
         decided_q <= 1'b1;
         style_q   <= STROBE_DIRDS;
      end else if (pick_split) begin
         decided_q <= 1'b1;
         style_q   <= STROBE_SPLIT;
      end
   end

endmodule

// File: rtl/hbd_muxsense.sv
module hbd_muxsense (
   input  logic clk,
   input  logic rst_n,
   input  logic freeze,
   input  logic now_a0,
   input  logic now_ale,
   input  logic prev_ale,
   output logic demux_q,
   output logic demux_eff,
   output logic ale_fall
);

   always_comb begin
      demux_eff = demux_q || (!freeze && now_a0);
      ale_fall  = !demux_eff && prev_ale && !now_ale;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         demux_q <= 1'b0;
      end else begin
         demux_q <= demux_eff;
      end
   end

endmodule

// File: rtl/hbd_xlate.sv
module hbd_xlate #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              dirds,
   input  logic              demux,
   input  logic              ale_fall,
   input  logic [ADDR_W-1:0] pin_addr,
   input  logic [DATA_W-1:0] pin_ad,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              addr_stb
);

   logic rd_act, wr_act, any_act;
   logic rd_q, wr_q, any_q;
   logic acc_start;

   always_comb begin
      if (dirds) begin
         rd_act = !cs_n && !rd_n && wr_n;
         wr_act = !cs_n && !rd_n && !wr_n;
      end else begin
         rd_act = !cs_n && !rd_n;
         wr_act = !cs_n && !wr_n && rd_n;
      end
      any_act   = rd_act || wr_act;
      acc_start = any_act && !any_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         wr_q      <= 1'b0;
         any_q     <= 1'b0;
         reg_rd    <= 1'b0;
         reg_wr    <= 1'b0;
         addr_stb  <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
      end else begin
         rd_q     <= rd_act;
         wr_q     <= wr_act;
         any_q    <= any_act;
         reg_rd   <= rd_act && !rd_q;
         reg_wr   <= wr_q && !wr_act;
         addr_stb <= demux ? acc_start : ale_fall;
         if (wr_act) begin
            reg_wdata <= pin_ad;
         end
         if (demux && acc_start) begin
            reg_addr <= pin_addr;
         end else if (!demux && ale_fall) begin
            reg_addr <= pin_ad[ADDR_W-1:0];
         end
      end
   end

endmodule

// File: rtl/hbus_detect.sv
module hbus_detect
   import hbus_detect_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic              host_ale,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_ad,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              addr_stb,
   output logic [STAT_W-1:0] mode_status
);

   localparam int PIN_W = CTL_W + ADDR_W + DATA_W;
   localparam logic [PIN_W-1:0] PIN_RST = {4'b1110, {(ADDR_W + DATA_W){1'b0}}};

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("hbus_detect: ADDR_W must be 1 to DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("hbus_detect: DATA_W must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0]  now_v, prev_v;
   host_ctl_t         now_c, prev_c;
   logic [ADDR_W-1:0] now_addr;
   logic [DATA_W-1:0] now_ad;

   hbd_sampler #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   ({host_cs_n, host_rd_n, host_wr_n, host_ale, host_addr, host_ad}),
      .now_q  (now_v),
      .prev_q (prev_v)
   );

   assign now_c    = host_ctl_t'(now_v[PIN_W-1 -: CTL_W]);
   assign prev_c   = host_ctl_t'(prev_v[PIN_W-1 -: CTL_W]);
   assign now_addr = now_v[DATA_W +: ADDR_W];
   assign now_ad   = now_v[DATA_W-1:0];

   logic          locked_q;
   strobe_style_e style_q;
   logic          dirds_eff;
   logic          demux_q, demux_eff, ale_fall;
   logic          read_sel;

   hbd_style u_style (
      .clk       (clk),
      .rst_n     (rst_n),
      .freeze    (locked_q),
      .now_c     (now_c),
      .prev_c    (prev_c),
      .style_q   (style_q),
      .dirds_eff (dirds_eff)
   );

   hbd_muxsense u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .freeze    (locked_q),
      .now_a0    (now_addr[0]),
      .now_ale   (now_c.ale),
      .prev_ale  (prev_c.ale),
      .demux_q   (demux_q),
      .demux_eff (demux_eff),
      .ale_fall  (ale_fall)
   );

   always_comb begin
      if (dirds_eff) begin
         read_sel = !now_c.cs_n && !now_c.rd_n && now_c.wr_n;
      end else begin
         read_sel = !now_c.cs_n && !now_c.rd_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
      end else if (read_sel) begin
         locked_q <= 1'b1;
      end
   end

   hbd_xlate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (now_c.cs_n),
      .rd_n      (now_c.rd_n),
      .wr_n      (now_c.wr_n),
      .dirds     (dirds_eff),
      .demux     (demux_eff),
      .ale_fall  (ale_fall),
      .pin_addr  (now_addr),
      .pin_ad    (now_ad),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .addr_stb  (addr_stb)
   );

   always_comb begin
      mode_status             = '0;
      mode_status[STAT_STYLE] = (style_q == STROBE_DIRDS);
      mode_status[STAT_DEMUX] = demux_q;
      mode_status[STAT_LOCK]  = locked_q;
   end

endmodule

// File: rtl/hbd_chk.sv
module hbd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_rd,
   input logic       reg_wr,
   input logic [2:0] mode_status
);

   assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_status[2] |=> mode_status[2]);

   assert_modes_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_status[2] |=> $stable(mode_status[1:0]));

   assert_demux_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_status[1] |=> mode_status[1]);

   assert_style_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_status[0] |=> mode_status[0]);

   assert_no_dual_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_wr));

   assert_read_after_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> mode_status[2]);

endmodule

bind hbus_detect hbd_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_rd      (reg_rd),
   .reg_wr      (reg_wr),
   .mode_status (mode_status)
);

// File: tb/sim_hbus_detect.sv
module sim_hbus_detect;

   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0;
   logic [AW-1:0] haddr = '0;
   logic [DW-1:0] ad = '0;
   logic          reg_rd, reg_wr, addr_stb;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [2:0]    mode_status;

   int n_vec = 0;
   int n_bad = 0;
   int wr_cnt = 0, rd_cnt = 0, stb_cnt = 0;
   logic [AW-1:0] last_waddr, last_raddr;
   logic [DW-1:0] last_wdata;
   bit tb_ds, tb_dmx;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hbus_detect #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_ale(ale),
      .host_addr(haddr), .host_ad(ad),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .addr_stb(addr_stb), .mode_status(mode_status)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr) begin
            wr_cnt++;
            last_waddr = reg_addr;
            last_wdata = reg_wdata;
         end
         if (reg_rd) begin
            rd_cnt++;
            last_raddr = reg_addr;
         end
         if (addr_stb) stb_cnt++;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one host access in the style and bus mode the bench is currently emulating
   task automatic access(input bit is_wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit sel);
      if (!tb_dmx) begin
         ad = DW'(a); ale = 1'b1; step(2);
         ale = 1'b0; step(2);
      end else begin
         haddr = a;
      end
      ad = is_wr ? d : '0;
      cs_n = !sel;
      if (tb_ds) begin
         wr_n = !is_wr; step(2);
         rd_n = 1'b0;   step(3);
         rd_n = 1'b1;   step(2);
         wr_n = 1'b1;
      end else begin
         if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
         step(3);
         wr_n = 1'b1; rd_n = 1'b1; step(2);
      end
      cs_n = 1'b1; step(3);
      haddr = '0; ad = '0;
      step(1);
   endtask

   // deselected traffic shaped like the opposite strobe style
   task automatic foreign_traffic();
      if (tb_ds) begin
         wr_n = 1'b0; step(2);
         wr_n = 1'b1; step(3);
      end else begin
         wr_n = 1'b0; step(2);
         rd_n = 1'b0; step(2);
         rd_n = 1'b1; step(2);
         wr_n = 1'b1; step(3);
      end
   endtask

   task automatic run_scenario(input bit ds, input bit dmx);
      int w0, r0, s0;
      logic [2:0] exp_st;
      tb_ds = ds; tb_dmx = dmx;
      rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ale = 1'b0;
      haddr = '0; ad = '0;
      step(3);
      // R1: reset state
      chk(mode_status == 3'b000, "R1 status", mode_status, 0);
      chk(!reg_rd && !reg_wr && !addr_stb, "R1 pulses", {reg_rd, reg_wr, addr_stb}, 0);
      rst_n = 1'b1; step(2);
      wr_cnt = 0; rd_cnt = 0; stb_cnt = 0;

      // classification write to an odd address
      access(1'b1, 4'd1, 8'h5A, 1'b1);
      exp_st = {1'b0, dmx, ds};
      chk(mode_status[0] == ds, ds ? "R3 style" : "R2 style", mode_status[0], ds);
      chk(mode_status[1] == dmx, "R4 demux", mode_status[1], dmx);
      chk(mode_status[2] == 1'b0, "R5 unlocked after write", mode_status[2], 0);
      chk(wr_cnt == 1 && rd_cnt == 0, ds ? "R8 first write" : "R7 first write", wr_cnt*10 + rd_cnt, 10);

      // R6: the other style's traffic before lock leaves the style alone
      foreign_traffic();
      chk(mode_status == exp_st, "R6 style kept", mode_status, exp_st);

      // locking read to an odd address
      access(1'b0, 4'd1, 8'h00, 1'b1);
      exp_st = {1'b1, dmx, ds};
      chk(mode_status == exp_st, "R5 locked", mode_status, exp_st);
      chk(rd_cnt == 1 && last_raddr == 4'd1, "R12 read pulse", rd_cnt, 1);

      // sweep all addresses: write then read
      for (int a = 0; a < (1 << AW); a++) begin
         logic [DW-1:0] dv;
         dv = DW'((a * 37 + 11) & 8'hFF);
         w0 = wr_cnt; r0 = rd_cnt; s0 = stb_cnt;
         access(1'b1, AW'(a), dv, 1'b1);
         chk(wr_cnt == w0 + 1 && rd_cnt == r0, ds ? "R8 write count" : "R7 write count", wr_cnt - w0, 1);
         chk(last_wdata == dv, ds ? "R8 wdata" : "R7 wdata", last_wdata, dv);
         chk(last_waddr == AW'(a), dmx ? "R10 waddr" : "R9 waddr", last_waddr, a);
         chk(stb_cnt == s0 + 1, dmx ? "R10 stb" : "R9 stb", stb_cnt - s0, 1);
         w0 = wr_cnt; r0 = rd_cnt;
         access(1'b0, AW'(a), '0, 1'b1);
         chk(rd_cnt == r0 + 1 && wr_cnt == w0, ds ? "R8 read count" : "R7 read count", rd_cnt - r0, 1);
         chk(last_raddr == AW'(a), dmx ? "R10 raddr" : "R9 raddr", last_raddr, a);
      end

      // R11: deselected accesses give no pulses
      w0 = wr_cnt; r0 = rd_cnt;
      access(1'b1, 4'd6, 8'hC3, 1'b0);
      access(1'b0, 4'd6, 8'h00, 1'b0);
      chk(wr_cnt == w0 && rd_cnt == r0, "R11 no pulse", (wr_cnt - w0) + (rd_cnt - r0), 0);

      // R5: activity after lock cannot change the modes
      haddr[0] = 1'b1; step(3); haddr = '0; step(2);
      foreign_traffic();
      chk(mode_status == exp_st, "R5 frozen", mode_status, exp_st);
      chk(wr_cnt == w0 && rd_cnt == r0, "R11 foreign deselected", (wr_cnt - w0) + (rd_cnt - r0), 0);
   endtask

   initial begin
      step(1);
      for (int sc = 0; sc < 4; sc++) begin
         run_scenario(sc[0], sc[1]);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule